// File: doc/BRIEF.md
# Serial ADC Interface Slave

This block is the digital serial front end of a 12-bit successive-approximation converter, with the analog path replaced by a parallel sample input. A host drives a chip select, a serial clock and a serial data line. The block finds a start bit on the data line and collects an 8-bit control byte. It then marks the start of a conversion with a one-period strobe and sends the 12-bit result out MSB first, one bit per serial-clock falling edge. The control byte also selects the input channel, the input configuration and a power mode for the analog side.

All serial inputs are synchronised to a fast local clock, and edges of the serial clock are found there. The data line is sampled on serial-clock rising edges, and the outputs change on falling edges. A new control byte may begin while the current result is still being sent, once a fixed point of the readout has passed, so conversions can follow each other every 16 serial clocks. A shutdown input aborts any conversion at once. The two serial outputs float while chip select is high.

Top module: `sadc_slave`

## Requirements
- R1: While chip select is low and the block is neither collecting a byte nor converting, zeros on the data line are ignored, and the first 1 sampled on a rising edge is the start bit and becomes bit 7 of the control byte. The other seven bits follow MSB first on the next seven rising edges.
- R2: During a conversion, 1s on the data line are ignored until the falling edge that drives result bit 6 has passed. The first 1 sampled after that edge starts the next control byte, so a byte may begin 14 serial clocks after the previous byte began, and a 16-clock repeat rate is sustained.
- R3: A conversion starts on the falling edge that follows the rising edge of the eighth control bit, and never without a complete control byte.
- R4: The strobe output is high for exactly one serial-clock period, from that falling edge to the next one.
- R5: On the 12 falling edges after the strobe edge, the data output carries the captured sample from bit 11 down to bit 0. At every other falling edge it drives 0, including every edge from reset until the first result.
- R6: While chip select is high, the data and strobe outputs are high impedance and serial-clock edges are ignored. Once chip select returns low, the strobe output drives 0.
- R7: While shutdown is low, any conversion and any partial control byte are dropped at once, both serial outputs drive 0, the data line is ignored and the power-mode output reads 00.
- R8: Control bits 1:0 request a power mode (11 run, 10 and 01 low-current modes, 00 full power-down). The power-mode output changes to the requested mode only on the falling edge after result bit 0 has been sent, never earlier.
- R9: At the strobe edge, control bits 6:4 appear on the channel-select output and bits 3:2 on the configuration output.
- R10: After reset, the power-mode output reads 11, the channel select and configuration read 0, and the data and strobe outputs drive 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock used to sample the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in, sampled on serial-clock rising edges |
| shdn_n | input | 1 | Hardware shutdown, active low |
| sample_in | input | RES_W | Parallel conversion result standing in for the analog path |
| dout | output | 1 | Serial result out, high impedance while chip select is high |
| sstrb | output | 1 | Conversion-start strobe, high impedance while chip select is high |
| ch_sel | output | 3 | Channel select for the sampling multiplexer |
| ana_cfg | output | 2 | Bit 1 bipolar select, bit 0 differential select |
| pwr_mode | output | 2 | Applied power mode |

## Verification
The hardest condition to reach from the ports is the edge of the overlap window. A 1 must arrive on the data line at the last rising edge before result bit 6 leaves the block, and a real start bit must arrive at the first rising edge after it. The bench builds a per-cycle schedule of data-line bits and expected outputs. It places each control byte at an exact serial-clock index relative to the previous one, with stray 1s on the cycles just inside the closed window, so a window that opens one edge early moves the strobe and is caught. The same schedule drives a back-to-back 16-clock stream, and it raises shutdown or chip select part way through a readout.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int CTL_W = 8;

  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_STBY = 2'b01,
    PM_NAP  = 2'b10,
    PM_RUN  = 2'b11
  } pwr_mode_e;

  // Layout of the received control byte, MSB first on the wire
  typedef struct packed {
    logic      start;
    logic [2:0] chan;
    logic      bipolar;
    logic      diff;
    pwr_mode_e pd;
  } ctl_byte_t;

endpackage

// File: rtl/sadc_rst_sync.sv
module sadc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n_sync = rst_q[1];

endmodule

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  genvar gi;
  for (gi = 0; gi < STAGES; gi++) begin : g_stage
    logic [W-1:0] q_r;
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= g_stage[gi-1].q_r;
      end
    end
  end

  assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/sadc_ctl_rx.sv
module sadc_ctl_rx #(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_en,
  input  logic             din,
  input  logic             start_ok,
  input  logic             take,
  output logic             ready,
  output logic [CTL_W-1:0] byte_q
);

  localparam int CNT_W = $clog2(CTL_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CTL_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CTL_W-1:0] sr_q, sr_d;

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    if (clr || take) begin
      cnt_d = '0;
    end else if (smp_en) begin
      if (cnt_q == '0) begin
        if (din && start_ok) begin
          cnt_d = CNT_W'(1);
          sr_d  = {{(CTL_W-1){1'b0}}, 1'b1};
        end
      end else if (cnt_q != FULL) begin
        cnt_d = cnt_q + 1'b1;
        sr_d  = {sr_q[CTL_W-2:0], din};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end

  assign ready  = (cnt_q == FULL);
  assign byte_q = sr_q;

endmodule

// File: rtl/sadc_sar_tx.sv
module sadc_sar_tx #(
  parameter int RES_W   = 12,
  parameter int WIN_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cs_hi,
  input  logic             shift_en,
  input  logic             load,
  input  logic [RES_W-1:0] sample,
  output logic             dout_q,
  output logic             sstrb_q,
  output logic             active_q,
  output logic             win_open,
  output logic             done
);

  localparam int FC_W = $clog2(RES_W + 1);
  localparam logic [FC_W-1:0] LAST = FC_W'(RES_W);
  localparam logic [FC_W-1:0] WIN  = FC_W'(RES_W - WIN_BIT);

  logic [RES_W-1:0] sr_q, sr_d;
  logic [FC_W-1:0]  fcnt_q, fcnt_d;
  logic             active_d, dout_d, sstrb_d;

  always_comb begin
    sr_d     = sr_q;
    fcnt_d   = fcnt_q;
    active_d = active_q;
    dout_d   = dout_q;
    sstrb_d  = sstrb_q;
    done     = 1'b0;
    if (clr) begin
      active_d = 1'b0;
      dout_d   = 1'b0;
      sstrb_d  = 1'b0;
      fcnt_d   = '0;
    end else begin
      if (cs_hi) sstrb_d = 1'b0;
      if (shift_en) begin
        if (load) begin
          sr_d     = sample;
          fcnt_d   = '0;
          active_d = 1'b1;
          sstrb_d  = 1'b1;
          dout_d   = 1'b0;
        end else if (active_q) begin
          sstrb_d = 1'b0;
          if (fcnt_q != LAST) begin
            dout_d = sr_q[RES_W-1];
            sr_d   = {sr_q[RES_W-2:0], 1'b0};
            fcnt_d = fcnt_q + 1'b1;
          end else begin
            active_d = 1'b0;
            dout_d   = 1'b0;
            done     = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      fcnt_q   <= '0;
      active_q <= 1'b0;
      dout_q   <= 1'b0;
      sstrb_q  <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      fcnt_q   <= fcnt_d;
      active_q <= active_d;
      dout_q   <= dout_d;
      sstrb_q  <= sstrb_d;
    end
  end

  assign win_open = active_q && (fcnt_q >= WIN);

endmodule

// File: rtl/sadc_slave.sv
module sadc_slave
  import sadc_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int WIN_BIT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             shdn_n,
  input  logic [RES_W-1:0] sample_in,
  output logic             dout,
  output logic             sstrb,
  output logic [2:0]       ch_sel,
  output logic [1:0]       ana_cfg,
  output logic [1:0]       pwr_mode
);

  logic       rst_n_i;
  logic [3:0] sy;
  logic       cs_s, sclk_s, din_s, shdn_s;
  logic       sclk_prev_q;
  logic       sclk_rise, sclk_fall;
  logic       ctl_ready, take, start_ok;
  logic [CTL_W-1:0] ctl_raw;
  ctl_byte_t  ctl;
  logic       dout_q, sstrb_q, active_q, win_open, done;

  logic [2:0] ch_q, ch_d;
  logic [1:0] ana_q, ana_d;
  pwr_mode_e  pend_q, pend_d, app_q, app_d;

  sadc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sadc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({shdn_n, din, sclk, cs_n}),
    .q     (sy)
  );

  assign cs_s   = sy[0];
  assign sclk_s = sy[1];
  assign din_s  = sy[2];
  assign shdn_s = sy[3];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sclk_prev_q <= 1'b0;
    else          sclk_prev_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q & ~cs_s & shdn_s;
  assign sclk_fall = ~sclk_s & sclk_prev_q & ~cs_s & shdn_s;
  assign start_ok  = ~active_q | win_open;

  sadc_ctl_rx #(.CTL_W(CTL_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (~shdn_s),
    .smp_en   (sclk_rise),
    .din      (din_s),
    .start_ok (start_ok),
    .take     (take),
    .ready    (ctl_ready),
    .byte_q   (ctl_raw)
  );

  assign ctl  = ctl_byte_t'(ctl_raw);
  assign take = sclk_fall & ctl_ready & ctl.start;

  sadc_sar_tx #(.RES_W(RES_W), .WIN_BIT(WIN_BIT)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (~shdn_s),
    .cs_hi    (cs_s),
    .shift_en (sclk_fall),
    .load     (take),
    .sample   (sample_in),
    .dout_q   (dout_q),
    .sstrb_q  (sstrb_q),
    .active_q (active_q),
    .win_open (win_open),
    .done     (done)
  );

  always_comb begin
    ch_d   = ch_q;
    ana_d  = ana_q;
    pend_d = pend_q;
    app_d  = app_q;
    if (take) begin
      ch_d   = ctl.chan;
      ana_d  = {ctl.bipolar, ctl.diff};
      pend_d = ctl.pd;
    end
    if (done) app_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ch_q   <= '0;
      ana_q  <= '0;
      pend_q <= PM_RUN;
      app_q  <= PM_RUN;
    end else begin
      ch_q   <= ch_d;
      ana_q  <= ana_d;
      pend_q <= pend_d;
      app_q  <= app_d;
    end
  end

  assign ch_sel   = ch_q;
  assign ana_cfg  = ana_q;
  assign pwr_mode = shdn_s ? app_q : PM_OFF;
  assign dout     = cs_n ? 1'bz : dout_q;
  assign sstrb    = cs_n ? 1'bz : sstrb_q;

endmodule

// File: rtl/sadc_slave_chk.sv
module sadc_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       shdn_s,
  input logic       fall_en,
  input logic       sstrb_q,
  input logic       dout_q,
  input logic       active_q,
  input logic       ready_q,
  input logic [1:0] pwr_applied
);

  // R4: strobe lasts one serial period
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sstrb_q && fall_en) |=> !sstrb_q);

  // R3: strobe only after a complete control byte
  a_r3_strobe_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb_q) |-> $past(ready_q));

  // R6: chip select high leaves the strobe low
  a_r6_cs_clears_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sstrb_q);

  // R7: shutdown drops the conversion
  a_r7_shdn_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_s |=> (!active_q && !dout_q && !sstrb_q));

  // R5: outside a conversion the data output is zero
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !dout_q);

  // R8: applied power mode holds while a conversion runs
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> $stable(pwr_applied));

endmodule

bind sadc_slave sadc_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_i),
  .cs_s        (cs_s),
  .shdn_s      (shdn_s),
  .fall_en     (sclk_fall),
  .sstrb_q     (sstrb_q),
  .dout_q      (dout_q),
  .active_q    (active_q),
  .ready_q     (ctl_ready),
  .pwr_applied (app_q)
);

// File: tb/sim_sadc_slave.sv
`timescale 1ns/1ps
module sim_sadc_slave;

  localparam int NC = 128;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din, shdn_n;
  logic [11:0] sample_in;
  tri1         dout_w, sstrb_w;
  logic [2:0]  ch_sel;
  logic [1:0]  ana_cfg, pwr_mode;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  logic        din_a [NC];
  logic        ed    [NC];
  logic        es    [NC];
  logic [11:0] sm    [NC];

  always #2 clk = ~clk;

  sadc_slave u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .din       (din),
    .shdn_n    (shdn_n),
    .sample_in (sample_in),
    .dout      (dout_w),
    .sstrb     (sstrb_w),
    .ch_sel    (ch_sel),
    .ana_cfg   (ana_cfg),
    .pwr_mode  (pwr_mode)
  );

  task automatic chk_bit(input string rq, input string what, input int cyc,
                         input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s cycle %0d: got %b expected %b", rq, what, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic clear_plan;
    for (int i = 0; i < NC; i++) begin
      din_a[i] = 1'b0; ed[i] = 1'b0; es[i] = 1'b0; sm[i] = '0;
    end
  endtask

  // control byte bits 7..0 on rises s..s+7, strobe at fall s+7, bit 12-k at fall s+7+k
  task automatic plan_conv(input int s, input logic [7:0] cb, input logic [11:0] v);
    for (int b = 0; b < 8; b++) begin
      din_a[s+b] = cb[7-b];
      sm[s+b]    = v;
    end
    es[s+7] = 1'b1;
    for (int k = 1; k <= 12; k++) ed[s+7+k] = v[12-k];
  endtask

  task automatic sck(input logic b);
    din = b;
    repeat (6) @(negedge clk);
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic run(input string scen, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      sample_in = sm[i];
      sck(din_a[i]);
      chk_bit({scen, " R5"}, "dout", i, dout_w, ed[i]);
      chk_bit({scen, " R3/R4"}, "sstrb", i, sstrb_w, es[i]);
    end
  endtask

  function automatic logic [7:0] mk_cb(input logic [2:0] ch, input logic [1:0] cfg,
                                       input logic [1:0] pd);
    return {1'b1, ch, cfg, pd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b0; din = 1'b0; shdn_n = 1'b1; sample_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R10: reset state
    chk_bit("R10", "dout", 0, dout_w, 1'b0);
    chk_bit("R10", "sstrb", 0, sstrb_w, 1'b0);
    chk_int("R10", "pwr_mode", pwr_mode, 3);
    chk_int("R10", "ch_sel", ch_sel, 0);
    chk_int("R10", "ana_cfg", ana_cfg, 0);

    // R5: zeros before any result, also leading zeros for R1
    clear_plan();
    run("R1", 0, 15);

    // R1 R3 R5 R9: sweep of result bit positions and channels
    for (int j = 0; j < 14; j++) begin
      logic [11:0] v;
      int s;
      v = (j < 12) ? (12'h001 << j) : ((j == 12) ? 12'hFFF : 12'h5A3);
      s = j % 3;
      clear_plan();
      plan_conv(s, mk_cb(3'(j % 8), 2'(j % 4), 2'b11), v);
      run("R1", 0, s + 21);
      chk_int("R9", "ch_sel", ch_sel, j % 8);
      chk_int("R9", "ana_cfg", ana_cfg, j % 4);
    end

    // R2: back-to-back 16-clock conversions
    clear_plan();
    for (int c = 0; c < 5; c++)
      plan_conv(c * 16, mk_cb(3'(7 - c), 2'(c), 2'b11), 12'((c + 1) * 12'h29B ^ 12'hC35));
    run("R2", 0, 4 * 16 + 21);
    chk_int("R9", "ch_sel after stream", ch_sel, 3);

    // R2: window boundary, stray ones at rises 9 and 13, real start at 14
    clear_plan();
    plan_conv(0, mk_cb(3'd1, 2'd2, 2'b11), 12'h9C6);
    din_a[9]  = 1'b1;
    din_a[13] = 1'b1;
    plan_conv(14, mk_cb(3'd6, 2'd1, 2'b11), 12'h36A);
    run("R2", 0, 14 + 23);
    chk_int("R9", "ch_sel second byte", ch_sel, 6);

    // R8: power mode applies after the last result bit
    clear_plan();
    plan_conv(1, mk_cb(3'd2, 2'd0, 2'b01), 12'hB71);
    run("R8", 0, 20);
    chk_int("R8", "pwr_mode before completion", pwr_mode, 3);
    run("R8", 21, 21);
    chk_int("R8", "pwr_mode after completion", pwr_mode, 1);
    clear_plan();
    plan_conv(0, mk_cb(3'd3, 2'd0, 2'b10), 12'h4E2);
    run("R8", 0, 19);
    chk_int("R8", "pwr_mode before completion", pwr_mode, 1);
    run("R8", 20, 21);
    chk_int("R8", "pwr_mode after completion", pwr_mode, 2);
    clear_plan();
    plan_conv(0, mk_cb(3'd0, 2'd0, 2'b11), 12'h0F0);
    run("R8", 0, 21);
    chk_int("R8", "pwr_mode restored", pwr_mode, 3);

    // R7: shutdown mid readout
    clear_plan();
    plan_conv(0, mk_cb(3'd5, 2'd3, 2'b11), 12'hABC);
    run("R7", 0, 12);
    shdn_n = 1'b0;
    repeat (8) @(negedge clk);
    chk_bit("R7", "dout in shutdown", 0, dout_w, 1'b0);
    chk_bit("R7", "sstrb in shutdown", 0, sstrb_w, 1'b0);
    chk_int("R7", "pwr_mode in shutdown", pwr_mode, 0);
    for (int i = 0; i < 10; i++) begin
      sck(1'b1);
      chk_bit("R7", "dout while din high", i, dout_w, 1'b0);
      chk_bit("R7", "sstrb while din high", i, sstrb_w, 1'b0);
    end
    shdn_n = 1'b1;
    repeat (8) @(negedge clk);
    chk_int("R7", "pwr_mode after shutdown", pwr_mode, 3);
    clear_plan();
    run("R7", 0, 24);
    clear_plan();
    plan_conv(2, mk_cb(3'd4, 2'd1, 2'b11), 12'h715);
    run("R7", 0, 24);

    // R6: chip select high floats outputs, strobe low once selected again
    clear_plan();
    plan_conv(0, mk_cb(3'd7, 2'd0, 2'b11), 12'hD29);
    run("R6", 0, 7);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_bit("R6", "dout released", 0, dout_w, 1'b1);
    chk_bit("R6", "sstrb released", 0, sstrb_w, 1'b1);
    for (int i = 0; i < 3; i++) begin
      sck(1'b1);
      chk_bit("R6", "dout released", i, dout_w, 1'b1);
      chk_bit("R6", "sstrb released", i, sstrb_w, 1'b1);
    end
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk_bit("R6", "sstrb driven low", 0, sstrb_w, 1'b0);
    chk_bit("R6", "dout driven", 0, dout_w, 1'b0);
    es[7] = 1'b0;
    run("R6", 8, 21);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule